// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

A synchronous reversible counter for a WIDTH-bit state (four bits by default). A parameter picks its modulus: decade, where the state runs 0 to 9, or full binary, where it runs 0 to 2^WIDTH-1. On each rising clock edge with the active-low count enable asserted, the state steps one place in the direction chosen by a direction input. While the enable is high the state holds.

An active-low preset drives the count output to a parallel value at once, whatever the clock is doing, and it wins over counting. Two cascade outputs let several counters be chained. The terminal flag rises when the next enabled step will wrap. The active-low cascade pulse is that flag, gated by the enable and the low phase of the clock. It can drive the enable or the clock of the next stage. An asynchronous active-low reset clears the state, and its release is taken in through a two-stage synchronizer.

Top module: `updown_counter`

## Requirements
- R1: While rst_n is low, and until the second rising edge after it rises, cnt is 0 (given ld_n high).
- R2: With ld_n high, cnt_en_n low and dir_dn low (0 = up), each rising edge adds one to cnt. The top value (9 in decade mode, 2^WIDTH-1 in binary mode) is followed by 0.
- R3: With ld_n high, cnt_en_n low and dir_dn high (1 = down), each rising edge subtracts one from cnt, and 0 is followed by the top value.
- R4: With ld_n high and cnt_en_n high, cnt holds across rising edges.
- R5: While ld_n is low, cnt equals ld_val in either clock phase, without waiting for an edge, and counting is overridden. If ld_val is steady when ld_n rises, cnt keeps that value until the next enabled edge.
- R6: In decade mode, an up count from a preset of 7 reads 8, 9, 0, 1, 2. The reverse count from 2 reads 1, 0, 9, 8, 7.
- R7: In decade mode, from any code 10 to 15, one enabled step in either direction gives 0.
- R8: term_flag is 1 exactly when (dir_dn = 0 and cnt = top) or (dir_dn = 1 and cnt = 0). It follows a change of dir_dn within the same clock phase.
- R9: cascade_n is 0 exactly when term_flag = 1, cnt_en_n = 0 and clk = 0. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_dn | input | 1 | Direction: 0 up, 1 down |
| ld_n | input | 1 | Asynchronous preset, active low |
| ld_val | input | WIDTH | Preset value |
| cnt | output | WIDTH | Current count |
| term_flag | output | 1 | Terminal count for the current direction |
| cascade_n | output | 1 | Cascade pulse, active low, clock-low phase |

## Verification
A binary and a decade instance share the same stimulus. Directed presets of 7 and 13 followed by up and down runs show the difference between the two wrap points. Inhibit stretches separate a holding state from a counting one. Flipping direction while sitting on 9 or 0 checks that the terminal flag and the cascade pulse follow the direction input alone. Presets applied in the clock-high phase and in the clock-low phase show that loading does not wait for an edge. Seeded random stimulus mixes enable, direction and preset values, so the decade instance also lands on codes 10 to 15 and must recover in one step.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;
endpackage

// File: rtl/udc_rst_sync.sv
module udc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/udc_step.sv
module udc_step
  import udc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int TOP   = 15
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP_V   = WIDTH'(TOP);
  localparam bit               HAS_GAP = (TOP < (2**WIDTH - 1));

  generate
    if (HAS_GAP) begin : g_gap
      // codes above TOP fall back to 0 in one step
      always_comb begin
        if (cur > TOP_V)
          nxt = '0;
        else if (dir == DIR_UP)
          nxt = (cur == TOP_V) ? '0 : cur + 1'b1;
        else
          nxt = (cur == '0) ? TOP_V : cur - 1'b1;
      end
    end else begin : g_full
      always_comb begin
        if (dir == DIR_UP)
          nxt = cur + 1'b1;
        else
          nxt = cur - 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/udc_term.sv
module udc_term
  import udc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int TOP   = 15
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  input  logic             en_n,
  output logic             flag,
  output logic             casc_n
);
  localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);

  always_comb begin
    if (dir == DIR_UP)
      flag = (cur == TOP_V);
    else
      flag = (cur == '0);
  end

  assign casc_n = ~(flag & ~en_n & ~clk);

  always_comb begin
    if (!casc_n) assert_casc_needs_flag_R9: assert (flag && !en_n);
  end
endmodule

// File: rtl/updown_counter.sv
module updown_counter
  import udc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_n,
  input  logic             dir_dn,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] ld_val,
  output logic [WIDTH-1:0] cnt,
  output logic             term_flag,
  output logic             cascade_n
);
  localparam int               TOP   = DECADE ? 9 : (2**WIDTH - 1);
  localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);

  logic             srst_n;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  dir_e             dir;

  assign dir = dir_e'(dir_dn);

  udc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  udc_step #(.WIDTH(WIDTH), .TOP(TOP)) u_step (
    .cur (cnt_q),
    .dir (dir),
    .nxt (cnt_d)
  );

  // preset is asynchronous and also recaptured on every edge while held
  always_ff @(posedge clk or negedge srst_n or negedge ld_n) begin
    if (!srst_n)
      cnt_q <= '0;
    else if (!ld_n)
      cnt_q <= ld_val;
    else if (!cnt_en_n)
      cnt_q <= cnt_d;
  end

  assign cnt = ld_n ? cnt_q : ld_val;

  udc_term #(.WIDTH(WIDTH), .TOP(TOP)) u_term (
    .clk    (clk),
    .cur    (cnt),
    .dir    (dir),
    .en_n   (cnt_en_n),
    .flag   (term_flag),
    .casc_n (cascade_n)
  );

  assert_hold_R4: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && ld_n && $past(ld_n) && $past(cnt_en_n)) |-> (cnt_q == $past(cnt_q)));

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && ld_n && $past(ld_n) && !$past(cnt_en_n) && !$past(dir_dn)
     && ($past(cnt_q) < TOP_V)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  assert_down_wrap_R3: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && ld_n && $past(ld_n) && !$past(cnt_en_n) && $past(dir_dn)
     && ($past(cnt_q) == '0)) |-> (cnt_q == TOP_V));

  assert_flag_at_end_R8: assert property (@(posedge clk) disable iff (!srst_n)
    term_flag |-> ((cnt == '0) || (cnt == TOP_V)));

  generate
    if (DECADE) begin : g_chk_dec
      assert_invalid_recover_R7: assert property (@(posedge clk) disable iff (!srst_n)
        ($past(srst_n) && ld_n && $past(ld_n) && !$past(cnt_en_n)
         && ($past(cnt_q) > TOP_V)) |-> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: tb/sim_updown_counter.sv
`timescale 1ns/1ps
module sim_updown_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en_n;
  logic       dir_dn;
  logic       ld_n;
  logic [3:0] ld_val;
  logic [3:0] cnt0, cnt1;
  logic       tf0, tf1, cs0, cs1;

  int ref_b, ref_d;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  updown_counter #(.WIDTH(4), .DECADE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .dir_dn(dir_dn),
    .ld_n(ld_n), .ld_val(ld_val), .cnt(cnt0), .term_flag(tf0), .cascade_n(cs0));

  updown_counter #(.WIDTH(4), .DECADE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .dir_dn(dir_dn),
    .ld_n(ld_n), .ld_val(ld_val), .cnt(cnt1), .term_flag(tf1), .cascade_n(cs1));

  function automatic int nxt(int q, bit dec, bit down);
    int top = dec ? 9 : 15;
    if (!down) return (q >= top) ? 0 : q + 1;
    if (q == 0) return top;
    return (q > top) ? 0 : q - 1;
  endfunction

  function automatic bit flag_of(int q, bit dec, bit down);
    int top = dec ? 9 : 15;
    return down ? (q == 0) : (q == top);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req);
    bit clo = !clk;
    chk({req, " R5/R2/R3 cnt bin"}, cnt0, ref_b);
    chk({req, " R6/R7 cnt dec"}, cnt1, ref_d);
    chk({req, " R8 flag bin"}, tf0, flag_of(ref_b, 0, dir_dn));
    chk({req, " R8 flag dec"}, tf1, flag_of(ref_d, 1, dir_dn));
    chk({req, " R9 cascade bin"}, cs0, !(flag_of(ref_b, 0, dir_dn) && !cnt_en_n && clo));
    chk({req, " R9 cascade dec"}, cs1, !(flag_of(ref_d, 1, dir_dn) && !cnt_en_n && clo));
  endtask

  task automatic upd();
    if (!ld_n) begin
      ref_b = ld_val; ref_d = ld_val;
    end else if (!cnt_en_n) begin
      ref_b = nxt(ref_b, 0, dir_dn);
      ref_d = nxt(ref_d, 1, dir_dn);
    end
  endtask

  // apply inputs in the clock-low phase, check low phase, edge, high phase
  task automatic cycle(bit en, bit dn, bit ld, logic [3:0] d, string req);
    @(negedge clk); #0.5;
    cnt_en_n = en; dir_dn = dn; ld_n = ld; ld_val = d;
    if (!ld) begin ref_b = d; ref_d = d; end
    #0.5 chk_all({req, " low"});
    @(posedge clk); upd();
    #1 chk_all({req, " high"});
  endtask

  // preset asserted in the clock-high phase
  task automatic load_high(logic [3:0] d, string req);
    @(posedge clk); upd();
    #1 ld_n = 1'b0; ld_val = d; ref_b = d; ref_d = d;
    #0.5 chk_all({req, " R5 load high phase"});
  endtask

  initial begin
    void'($urandom(32'h1d5));
    rst_n = 1'b0; cnt_en_n = 1'b1; dir_dn = 1'b0; ld_n = 1'b1; ld_val = 4'd0;
    ref_b = 0; ref_d = 0;
    #12 chk_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1; cnt_en_n = 1'b0;
    @(posedge clk); #1 chk_all("R1 sync stage 1");
    @(posedge clk); #1 chk_all("R1 sync stage 2");
    @(negedge clk); cnt_en_n = 1'b1;
    repeat (2) cycle(1, 0, 1, 0, "R4 idle");

    // preset 7 then up, inhibit, down
    cycle(1, 0, 0, 4'd7, "R5 load7");
    for (int i = 0; i < 5; i++) cycle(0, 0, 1, 4'd0, "R6 up from 7");
    for (int i = 0; i < 3; i++) cycle(1, 0, 1, 4'd0, "R4 inhibit");
    for (int i = 0; i < 5; i++) cycle(0, 1, 1, 4'd0, "R6 down to 7");

    // preset 13 in high phase then up / down
    load_high(4'd13, "R5 load13");
    cycle(1, 0, 1, 4'd13, "R5 release");
    for (int i = 0; i < 5; i++) cycle(0, 0, 1, 4'd0, "R2 up wrap");
    for (int i = 0; i < 5; i++) cycle(0, 1, 1, 4'd0, "R3 down wrap");

    // direction flip on terminal values
    cycle(1, 0, 0, 4'd9, "R8 load9");
    cycle(0, 0, 1, 4'd0, "R8 up at 9");
    cycle(1, 1, 0, 4'd0, "R8 load0");
    cycle(0, 0, 1, 4'd0, "R8 dir up at 0");
    cycle(0, 1, 1, 4'd0, "R8 dir dn");
    cycle(1, 0, 0, 4'd15, "R9 load15");
    cycle(0, 0, 1, 4'd0, "R9 casc up");
    cycle(0, 1, 1, 4'd0, "R9 casc flip");

    // invalid decade codes
    for (int c = 10; c < 16; c++) begin
      cycle(1, c[0], 0, 4'(c), "R7 load bad");
      cycle(0, c[0], 1, 4'd0, "R7 recover");
    end

    // preset overrides counting across an edge
    cycle(0, 0, 0, 4'd4, "R5 override");
    cycle(0, 0, 0, 4'd4, "R5 override2");

    for (int i = 0; i < 400; i++) begin
      bit ld = ($urandom_range(0, 9) != 0);
      cycle(1'($urandom_range(0, 3) == 0), 1'($urandom), ld, 4'($urandom), "random");
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule